// File: doc/BRIEF.md
# Named Barrier Warp Tracker

This block keeps track of which warps of a multi-warp compute core are parked at which named barrier. Each thread group (a cooperative group of warps) can use several barrier IDs at once. For every ID the block holds a set of warps that have arrived. A separate waiting mask tells the issue logic which warps must not be scheduled.

Events come in one per cycle on a single event port. Each event is one of four kinds:
- **Group allocation** carries a group ID and a warp mask.
- **Group release** carries a group ID.
- **Barrier arrival** carries a group, a warp, a barrier ID, a barrier kind and an optional thread count.
- **Warp exit** carries a group and a warp.

When a barrier completes, the block emits a one-cycle release pulse. The pulse carries a one-hot mask of the released barrier IDs and the mask of warps it frees. If any released warp arrived with the reducing kind, a broadcast request for that ID is raised in the same cycle so that the reduction result can be handed back. Instruction decode, pipeline state and the reduction arithmetic live elsewhere.

Top module: `nbt_barrier_tracker`

## Requirements
- R1: After reset, `stall_mask`, `rel_valid`, `rel_bar_mask`, `rel_warps`, `bcast_bar_mask`, `err_event` and `err_dealloc` are all zero.
- R2: An accepted arrival of kind 0 (sync) or kind 2 (reduce) sets that warp's bit in `stall_mask` one cycle later. The bit stays set until a release that includes the warp.
- R3: An accepted arrival of kind 1 (arrive) adds the warp to the barrier ID's arrived set, but never sets its `stall_mask` bit.
- R4: With `ev_has_count` low, a barrier completes when its arrived warps that belong to the group equal the group's active warps. In the next cycle `rel_valid` is high, `rel_bar_mask` has the bit of that ID set, `rel_warps` holds the released warps, and those warps are clear in `stall_mask`.
- R5: With `ev_has_count` high, a barrier completes when the number of the group's arrived warps times `WARP_SIZE` equals `ev_count`, even if other active warps have not arrived.
- R6: Arrivals at one barrier ID, or from another group, neither complete nor alter the arrived set of another ID or group.
- R7: A release whose freed warps include one that arrived with kind 2 sets that ID's bit in `bcast_bar_mask` in the same cycle as `rel_valid`. No other release sets it.
- R8: A group allocation (ev_op 0) marks its warps active and clears them from `stall_mask` and from every arrived set, so earlier arrivals no longer count.
- R9: A warp exit (ev_op 3) removes the warp from the active set. Every barrier ID whose non-empty arrived set then equals the group's remaining active warps is released.
- R10: A group release (ev_op 1) while any of its warps is still in an arrived set raises `err_dealloc` for one cycle; otherwise `err_dealloc` stays low. Either way the group's warps are cleared from all state.
- R11: An arrival (ev_op 2) is rejected if the warp is not in a live group, the barrier ID is `NUM_BARS` or more, or the kind is 3. An exit from a warp not in the group is also rejected. A rejected event raises `err_event` for one cycle and changes neither `stall_mask` nor any barrier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_valid | input | 1 | Event present this cycle |
| ev_op | input | 2 | 0 allocate group, 1 release group, 2 barrier arrival, 3 warp exit |
| ev_cta | input | CTA_W | Group ID |
| ev_mask | input | NUM_WARPS | Warp mask of an allocated group |
| ev_warp | input | WARP_W | Warp of an arrival or exit |
| ev_bar | input | BID_W | Barrier ID (one extra bit so out-of-range IDs are visible) |
| ev_kind | input | 2 | 0 sync, 1 arrive, 2 reduce |
| ev_has_count | input | 1 | Use `ev_count` as release condition |
| ev_count | input | CNT_W | Thread count for counted release |
| stall_mask | output | NUM_WARPS | Warps held at a barrier |
| rel_valid | output | 1 | Release pulse |
| rel_bar_mask | output | NUM_BARS | Barrier IDs released |
| rel_warps | output | NUM_WARPS | Warps released |
| bcast_bar_mask | output | NUM_BARS | Reduction broadcast requests |
| err_event | output | 1 | Rejected arrival or exit |
| err_dealloc | output | 1 | Group released with warps still held |

## Verification
The hardest situation to reach is a barrier that is completed by a warp leaving rather than by one arriving. The stimulus parks three warps of a four-warp group at one ID and then retires the fourth through an exit event. It then checks that a release appears with no arrival in that cycle. A second hard case is a stale arrival that survives a re-allocation. To cover it, one warp arrives, its group is re-allocated, and the other three warps arrive; the bench confirms that no release fires until the first warp arrives again.

// File: rtl/nbt_pkg.sv
// Shared encodings for the named barrier warp tracker.
package nbt_pkg;
    typedef enum logic [1:0] {
        EV_ALLOC   = 2'd0,
        EV_DEALLOC = 2'd1,
        EV_ARRIVE  = 2'd2,
        EV_EXIT    = 2'd3
    } ev_op_e;

    typedef enum logic [1:0] {
        BK_SYNC    = 2'd0,
        BK_ARRIVE  = 2'd1,
        BK_REDUCE  = 2'd2,
        BK_INVALID = 2'd3
    } bar_kind_e;
endpackage

// File: rtl/nbt_cta_table.sv
// Group table: holds the warp mask and live flag of every group.
// Assumes at most one allocate or release per cycle; a re-allocation overwrites.
module nbt_cta_table #(
    parameter int NUM_CTAS  = 4,
    parameter int NUM_WARPS = 8,
    localparam int CTA_W    = (NUM_CTAS > 1) ? $clog2(NUM_CTAS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 alloc_en,
    input  logic                 free_en,
    input  logic [CTA_W-1:0]     cta_id,
    input  logic [NUM_WARPS-1:0] alloc_mask,
    output logic [NUM_WARPS-1:0] sel_mask,
    output logic                 sel_live
);
    logic [NUM_WARPS-1:0] masks [NUM_CTAS];
    logic [NUM_CTAS-1:0]  live;

    // Look up the group addressed by the current event.
    always_comb begin
        sel_mask = '0;
        sel_live = 1'b0;
        for (int c = 0; c < NUM_CTAS; c++) begin
            if (cta_id == CTA_W'(c)) begin
                sel_mask = masks[c];
                sel_live = live[c];
            end
        end
    end

    // Record allocations and releases per group.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live <= '0;
            for (int c = 0; c < NUM_CTAS; c++) masks[c] <= '0;
        end else begin
            for (int c = 0; c < NUM_CTAS; c++) begin
                if (cta_id == CTA_W'(c)) begin
                    if (alloc_en) begin
                        masks[c] <= alloc_mask;
                        live[c]  <= 1'b1;
                    end else if (free_en) begin
                        masks[c] <= '0;
                        live[c]  <= 1'b0;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/nbt_bar_slot.sv
// One barrier ID: arrived-warp set, reducing-warp set and completion test.
// Arrived sets are shared by all groups; groups never share warps, so the
// group mask partitions the set. Assumes at most one arrival per cycle.
module nbt_bar_slot #(
    parameter int NUM_WARPS = 8,
    parameter int WARP_SIZE = 32,
    parameter int CNT_W     = 9
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_WARPS-1:0] clr_mask,
    input  logic                 arr_en,
    input  logic [NUM_WARPS-1:0] arr_onehot,
    input  logic                 arr_red,
    input  logic [NUM_WARPS-1:0] cta_mask,
    input  logic [NUM_WARPS-1:0] act_mask,
    input  logic                 use_count,
    input  logic [CNT_W-1:0]     thr_count,
    input  logic                 exit_chk,
    output logic                 rel,
    output logic [NUM_WARPS-1:0] rel_warps,
    output logic                 rel_red,
    output logic [NUM_WARPS-1:0] arrived_o
);
    logic [NUM_WARPS-1:0] arrived, red_set;
    logic [NUM_WARPS-1:0] nxt, red_nxt, at;
    logic [CNT_W-1:0]     pc, prod;
    logic                 full, cnt_ok;

    assign arrived_o = arrived;

    // Merge the new arrival and isolate the addressed group's warps.
    always_comb begin
        nxt     = arrived | (arr_en ? arr_onehot : '0);
        red_nxt = red_set | ((arr_en && arr_red) ? arr_onehot : '0);
        at      = nxt & cta_mask;
    end

    // Count arrived warps of the group for the counted release mode.
    always_comb begin
        pc = '0;
        for (int w = 0; w < NUM_WARPS; w++) pc = pc + CNT_W'(at[w]);
        prod   = pc * CNT_W'(WARP_SIZE);
        cnt_ok = (prod == thr_count) && (|at);
        full   = (at == act_mask) && (|at);
    end

    // Decide completion for an arrival or an exit recheck.
    always_comb begin
        rel       = (arr_en && (use_count ? cnt_ok : full)) || (exit_chk && full);
        rel_warps = rel ? at : '0;
        rel_red   = rel && (|(red_nxt & at));
    end

    // Update the arrived and reducing sets.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arrived <= '0;
            red_set <= '0;
        end else begin
            arrived <= nxt & ~clr_mask & ~rel_warps;
            red_set <= red_nxt & ~clr_mask & ~rel_warps;
        end
    end
endmodule

// File: rtl/nbt_barrier_tracker.sv
// Named barrier warp tracker top: decodes one event per cycle, keeps the
// active and waiting masks, and drives registered release, broadcast and
// error pulses one cycle after the causing event.
module nbt_barrier_tracker #(
    parameter int NUM_WARPS = 8,
    parameter int NUM_CTAS  = 4,
    parameter int NUM_BARS  = 16,
    parameter int WARP_SIZE = 32,
    localparam int CTA_W    = (NUM_CTAS > 1) ? $clog2(NUM_CTAS) : 1,
    localparam int WARP_W   = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1,
    localparam int BID_W    = $clog2(NUM_BARS) + 1,
    localparam int CNT_W    = $clog2(NUM_WARPS * WARP_SIZE + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ev_valid,
    input  logic [1:0]           ev_op,
    input  logic [CTA_W-1:0]     ev_cta,
    input  logic [NUM_WARPS-1:0] ev_mask,
    input  logic [WARP_W-1:0]    ev_warp,
    input  logic [BID_W-1:0]     ev_bar,
    input  logic [1:0]           ev_kind,
    input  logic                 ev_has_count,
    input  logic [CNT_W-1:0]     ev_count,
    output logic [NUM_WARPS-1:0] stall_mask,
    output logic                 rel_valid,
    output logic [NUM_BARS-1:0]  rel_bar_mask,
    output logic [NUM_WARPS-1:0] rel_warps,
    output logic [NUM_BARS-1:0]  bcast_bar_mask,
    output logic                 err_event,
    output logic                 err_dealloc
);
    import nbt_pkg::*;

    logic is_alloc, is_free, is_arrive, is_exit;
    logic in_cta, bar_ok, kind_ok, arr_ok, exit_ok, held_any;
    logic [NUM_WARPS-1:0] warp_oh, sel_mask, clr_mask, act_mask;
    logic [NUM_WARPS-1:0] active, waiting, active_nxt, waiting_nxt;
    logic [NUM_WARPS-1:0] rel_union, held_union;
    logic [NUM_BARS-1:0]  slot_rel, slot_red;
    logic [NUM_WARPS-1:0] slot_warps [NUM_BARS];
    logic [NUM_WARPS-1:0] slot_arr   [NUM_BARS];
    logic sel_live;

    // Decode the event and validate it against the group table.
    always_comb begin
        is_alloc  = ev_valid && (ev_op == EV_ALLOC);
        is_free   = ev_valid && (ev_op == EV_DEALLOC);
        is_arrive = ev_valid && (ev_op == EV_ARRIVE);
        is_exit   = ev_valid && (ev_op == EV_EXIT);
        warp_oh   = NUM_WARPS'(1) << ev_warp;
        in_cta    = sel_live && (|(sel_mask & warp_oh));
        bar_ok    = ev_bar < BID_W'(NUM_BARS);
        kind_ok   = ev_kind != BK_INVALID;
        arr_ok    = is_arrive && in_cta && bar_ok && kind_ok;
        exit_ok   = is_exit && in_cta;
        clr_mask  = is_alloc ? ev_mask : ((is_free && sel_live) ? sel_mask : '0);
        act_mask  = sel_mask & active & ~(exit_ok ? warp_oh : '0);
    end

    nbt_cta_table #(.NUM_CTAS(NUM_CTAS), .NUM_WARPS(NUM_WARPS)) u_table (
        .clk        (clk),
        .rst_n      (rst_n),
        .alloc_en   (is_alloc),
        .free_en    (is_free),
        .cta_id     (ev_cta),
        .alloc_mask (ev_mask),
        .sel_mask   (sel_mask),
        .sel_live   (sel_live)
    );

    for (genvar b = 0; b < NUM_BARS; b++) begin : g_slot
        nbt_bar_slot #(.NUM_WARPS(NUM_WARPS), .WARP_SIZE(WARP_SIZE), .CNT_W(CNT_W)) u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .clr_mask   (clr_mask),
            .arr_en     (arr_ok && (ev_bar == BID_W'(b))),
            .arr_onehot (warp_oh),
            .arr_red    (ev_kind == BK_REDUCE),
            .cta_mask   (sel_mask),
            .act_mask   (act_mask),
            .use_count  (ev_has_count),
            .thr_count  (ev_count),
            .exit_chk   (exit_ok),
            .rel        (slot_rel[b]),
            .rel_warps  (slot_warps[b]),
            .rel_red    (slot_red[b]),
            .arrived_o  (slot_arr[b])
        );
    end

    // Gather released warps and warps still held by any barrier.
    always_comb begin
        rel_union  = '0;
        held_union = '0;
        for (int b = 0; b < NUM_BARS; b++) begin
            rel_union  = rel_union | slot_warps[b];
            held_union = held_union | slot_arr[b];
        end
        held_any = is_free && sel_live && (|(held_union & sel_mask));
    end

    // Next active and waiting masks.
    always_comb begin
        active_nxt = active;
        if (is_alloc)      active_nxt = active | ev_mask;
        else if (is_free)  active_nxt = active & ~clr_mask;
        else if (exit_ok)  active_nxt = active & ~warp_oh;
        waiting_nxt = (waiting | ((arr_ok && ev_kind != BK_ARRIVE) ? warp_oh : '0))
                      & ~clr_mask & ~rel_union;
    end

    // Register state and one-cycle output pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active         <= '0;
            waiting        <= '0;
            rel_valid      <= 1'b0;
            rel_bar_mask   <= '0;
            rel_warps      <= '0;
            bcast_bar_mask <= '0;
            err_event      <= 1'b0;
            err_dealloc    <= 1'b0;
        end else begin
            active         <= active_nxt;
            waiting        <= waiting_nxt;
            rel_valid      <= |slot_rel;
            rel_bar_mask   <= slot_rel;
            rel_warps      <= rel_union;
            bcast_bar_mask <= slot_red;
            err_event      <= (is_arrive && !arr_ok) || (is_exit && !exit_ok);
            err_dealloc    <= held_any;
        end
    end

    assign stall_mask = waiting;
endmodule

// File: rtl/nbt_barrier_tracker_chk.sv
// Port-level checker for the named barrier warp tracker, bound to the top.
module nbt_barrier_tracker_chk #(
    parameter int NUM_WARPS = 8,
    parameter int NUM_CTAS  = 4,
    parameter int NUM_BARS  = 16,
    parameter int WARP_SIZE = 32,
    localparam int CTA_W    = (NUM_CTAS > 1) ? $clog2(NUM_CTAS) : 1,
    localparam int WARP_W   = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1,
    localparam int BID_W    = $clog2(NUM_BARS) + 1,
    localparam int CNT_W    = $clog2(NUM_WARPS * WARP_SIZE + 1)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 ev_valid,
    input logic [1:0]           ev_op,
    input logic [CTA_W-1:0]     ev_cta,
    input logic [NUM_WARPS-1:0] ev_mask,
    input logic [WARP_W-1:0]    ev_warp,
    input logic [BID_W-1:0]     ev_bar,
    input logic [1:0]           ev_kind,
    input logic                 ev_has_count,
    input logic [CNT_W-1:0]     ev_count,
    input logic [NUM_WARPS-1:0] stall_mask,
    input logic                 rel_valid,
    input logic [NUM_BARS-1:0]  rel_bar_mask,
    input logic [NUM_WARPS-1:0] rel_warps,
    input logic [NUM_BARS-1:0]  bcast_bar_mask,
    input logic                 err_event,
    input logic                 err_dealloc
);
    assert_arrive_no_stall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && ev_op == 2'd2 && ev_kind == 2'd1 && !stall_mask[ev_warp])
        |=> !stall_mask[$past(ev_warp)]);

    assert_released_unstalled_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rel_valid |-> ((rel_warps & stall_mask) == '0));

    assert_bcast_with_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (|bcast_bar_mask) |-> (rel_valid && ((bcast_bar_mask & ~rel_bar_mask) == '0)));

    assert_alloc_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && ev_op == 2'd0) |=> ((stall_mask & $past(ev_mask)) == '0));

    assert_bad_id_rejected_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && ev_op == 2'd2 && ev_bar >= BID_W'(NUM_BARS)) |=> (err_event && !rel_valid));
endmodule

bind nbt_barrier_tracker nbt_barrier_tracker_chk #(
    .NUM_WARPS(NUM_WARPS), .NUM_CTAS(NUM_CTAS), .NUM_BARS(NUM_BARS), .WARP_SIZE(WARP_SIZE)
) u_chk (.*);

// File: tb/nbt_barrier_tracker_tb.sv
module nbt_barrier_tracker_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ev_valid = 1'b0;
    logic [1:0] ev_op = '0;
    logic [1:0] ev_cta = '0;
    logic [7:0] ev_mask = '0;
    logic [2:0] ev_warp = '0;
    logic [4:0] ev_bar = '0;
    logic [1:0] ev_kind = '0;
    logic       ev_has_count = 1'b0;
    logic [8:0] ev_count = '0;
    logic [7:0]  stall_mask, rel_warps;
    logic        rel_valid, err_event, err_dealloc;
    logic [15:0] rel_bar_mask, bcast_bar_mask;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    nbt_barrier_tracker u_dut (
        .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_op(ev_op), .ev_cta(ev_cta),
        .ev_mask(ev_mask), .ev_warp(ev_warp), .ev_bar(ev_bar), .ev_kind(ev_kind),
        .ev_has_count(ev_has_count), .ev_count(ev_count), .stall_mask(stall_mask),
        .rel_valid(rel_valid), .rel_bar_mask(rel_bar_mask), .rel_warps(rel_warps),
        .bcast_bar_mask(bcast_bar_mask), .err_event(err_event), .err_dealloc(err_dealloc)
    );

    typedef struct packed {
        logic [1:0]  op;
        logic [1:0]  cta;
        logic [7:0]  mask;
        logic [2:0]  warp;
        logic [4:0]  bar;
        logic [1:0]  kind;
        logic        hc;
        logic [8:0]  cnt;
        logic [7:0]  stall;
        logic        rv;
        logic [15:0] rbars;
        logic [7:0]  rwarps;
        logic [15:0] bc;
    } vec_t;

    // Groups 0 (warps 0-3) and 1 (warps 4-7); R2 R3 R4 R5 R6 R7 exercised in order.
    localparam vec_t VEC [11] = '{
        '{2'd0, 2'd0, 8'h0F, 3'd0, 5'd0, 2'd0, 1'b0, 9'd0,  8'h00, 1'b0, 16'h0000, 8'h00, 16'h0000},
        '{2'd0, 2'd1, 8'hF0, 3'd0, 5'd0, 2'd0, 1'b0, 9'd0,  8'h00, 1'b0, 16'h0000, 8'h00, 16'h0000},
        '{2'd2, 2'd0, 8'h00, 3'd0, 5'd3, 2'd0, 1'b0, 9'd0,  8'h01, 1'b0, 16'h0000, 8'h00, 16'h0000},
        '{2'd2, 2'd0, 8'h00, 3'd1, 5'd3, 2'd1, 1'b0, 9'd0,  8'h01, 1'b0, 16'h0000, 8'h00, 16'h0000},
        '{2'd2, 2'd1, 8'h00, 3'd4, 5'd3, 2'd0, 1'b0, 9'd0,  8'h11, 1'b0, 16'h0000, 8'h00, 16'h0000},
        '{2'd2, 2'd1, 8'h00, 3'd5, 5'd7, 2'd0, 1'b0, 9'd0,  8'h31, 1'b0, 16'h0000, 8'h00, 16'h0000},
        '{2'd2, 2'd0, 8'h00, 3'd3, 5'd3, 2'd0, 1'b0, 9'd0,  8'h39, 1'b0, 16'h0000, 8'h00, 16'h0000},
        '{2'd2, 2'd0, 8'h00, 3'd2, 5'd3, 2'd2, 1'b0, 9'd0,  8'h30, 1'b1, 16'h0008, 8'h0F, 16'h0008},
        '{2'd2, 2'd1, 8'h00, 3'd6, 5'd7, 2'd0, 1'b1, 9'd64, 8'h10, 1'b1, 16'h0080, 8'h60, 16'h0000},
        '{2'd2, 2'd1, 8'h00, 3'd7, 5'd3, 2'd0, 1'b1, 9'd64, 8'h00, 1'b1, 16'h0008, 8'h90, 16'h0000},
        '{2'd2, 2'd0, 8'h00, 3'd0, 5'd0, 2'd1, 1'b1, 9'd32, 8'h00, 1'b1, 16'h0001, 8'h01, 16'h0000}
    };

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Apply one event at a negedge; outputs are sampled at the next negedge.
    task automatic ev(input logic [1:0] op, input logic [1:0] cta, input logic [7:0] mask,
                      input logic [2:0] warp, input logic [4:0] bar, input logic [1:0] kind,
                      input logic hc, input logic [8:0] cnt);
        ev_valid = 1'b1; ev_op = op; ev_cta = cta; ev_mask = mask; ev_warp = warp;
        ev_bar = bar; ev_kind = kind; ev_has_count = hc; ev_count = cnt;
        @(negedge clk);
        ev_valid = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1 reset state
        check("R1", "stall", 32'(stall_mask), 0);
        check("R1", "pulses", {rel_valid, err_event, err_dealloc}, 0);
        check("R1", "masks", {rel_bar_mask, bcast_bar_mask}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < 11; i++) begin
            ev(VEC[i].op, VEC[i].cta, VEC[i].mask, VEC[i].warp, VEC[i].bar, VEC[i].kind, VEC[i].hc, VEC[i].cnt);
            check("R2 R3 R6", $sformatf("vec %0d stall", i), 32'(stall_mask), 32'(VEC[i].stall));
            check("R4 R5", $sformatf("vec %0d rel_valid", i), 32'(rel_valid), 32'(VEC[i].rv));
            check("R4 R6", $sformatf("vec %0d rel_bar", i), 32'(rel_bar_mask), 32'(VEC[i].rbars));
            check("R4 R5", $sformatf("vec %0d rel_warps", i), 32'(rel_warps), 32'(VEC[i].rwarps));
            check("R7", $sformatf("vec %0d bcast", i), 32'(bcast_bar_mask), 32'(VEC[i].bc));
        end

        // R11: warp outside group, then barrier ID out of range
        ev(2'd2, 2'd0, 8'h00, 3'd5, 5'd1, 2'd0, 1'b0, 9'd0);
        check("R11", "err foreign warp", 32'(err_event), 1);
        check("R11", "stall foreign warp", 32'(stall_mask), 0);
        ev(2'd2, 2'd0, 8'h00, 3'd1, 5'd16, 2'd0, 1'b0, 9'd0);
        check("R11", "err id 16", 32'(err_event), 1);
        check("R11", "stall id 16", 32'(stall_mask), 0);
        check("R11", "no release id 16", 32'(rel_valid), 0);

        // R9: three warps wait at ID 2, the fourth exits
        ev(2'd2, 2'd1, 8'h00, 3'd4, 5'd2, 2'd0, 1'b0, 9'd0);
        ev(2'd2, 2'd1, 8'h00, 3'd5, 5'd2, 2'd0, 1'b0, 9'd0);
        ev(2'd2, 2'd1, 8'h00, 3'd6, 5'd2, 2'd0, 1'b0, 9'd0);
        check("R9", "stall before exit", 32'(stall_mask), 32'h70);
        check("R9", "no early release", 32'(rel_valid), 0);
        ev(2'd3, 2'd1, 8'h00, 3'd7, 5'd0, 2'd0, 1'b0, 9'd0);
        check("R9", "exit release", 32'(rel_valid), 1);
        check("R9", "exit rel_bar", 32'(rel_bar_mask), 32'h0004);
        check("R9", "exit rel_warps", 32'(rel_warps), 32'h70);
        check("R9", "exit stall", 32'(stall_mask), 0);

        // R10: release a group with a held warp, then a clean group
        ev(2'd2, 2'd1, 8'h00, 3'd4, 5'd9, 2'd0, 1'b0, 9'd0);
        check("R10", "held stall", 32'(stall_mask), 32'h10);
        ev(2'd1, 2'd1, 8'h00, 3'd0, 5'd0, 2'd0, 1'b0, 9'd0);
        check("R10", "err_dealloc held", 32'(err_dealloc), 1);
        check("R10", "stall cleared", 32'(stall_mask), 0);

        // R8: stale arrival dropped by re-allocation
        ev(2'd2, 2'd0, 8'h00, 3'd1, 5'd4, 2'd0, 1'b0, 9'd0);
        check("R8", "pre-alloc stall", 32'(stall_mask), 32'h02);
        ev(2'd0, 2'd0, 8'h0F, 3'd0, 5'd0, 2'd0, 1'b0, 9'd0);
        check("R8", "alloc clears stall", 32'(stall_mask), 0);
        ev(2'd2, 2'd0, 8'h00, 3'd0, 5'd4, 2'd0, 1'b0, 9'd0);
        ev(2'd2, 2'd0, 8'h00, 3'd2, 5'd4, 2'd0, 1'b0, 9'd0);
        ev(2'd2, 2'd0, 8'h00, 3'd3, 5'd4, 2'd0, 1'b0, 9'd0);
        check("R8", "stale not counted", 32'(rel_valid), 0);
        check("R8", "stall three", 32'(stall_mask), 32'h0D);
        ev(2'd2, 2'd0, 8'h00, 3'd1, 5'd4, 2'd0, 1'b0, 9'd0);
        check("R8", "release after rearrive", 32'(rel_warps), 32'h0F);
        check("R8", "stall after release", 32'(stall_mask), 0);

        ev(2'd1, 2'd0, 8'h00, 3'd0, 5'd0, 2'd0, 1'b0, 9'd0);
        check("R10", "err_dealloc clean", 32'(err_dealloc), 0);

        finish_run();
    end
endmodule